// File: doc/BRIEF.md
# GPIO Port Data Register

This block holds the data latch of a 16-pin general-purpose I/O port and sits on a simple memory-mapped bus. Bit n of the latch belongs to pin n. A direction vector from a separate pin-function controller marks each pin as a general output or a general input. Output pins are driven from the latch. A read returns, bit by bit, either the latch content (output pins) or the pin level (input pins). Pin levels pass through a two-stage synchroniser before they reach the read path.

The block answers at one word-aligned address and accepts 8-bit and 16-bit accesses. Byte lanes are big-endian: the byte at the word address is bits 15:8, and the byte at the next address is bits 7:0. Write data for a byte access is taken from the lane it selects, and byte read data is returned in that same lane. Writes complete on the strobe edge. Read data is registered and appears one cycle after the strobe, together with a one-cycle valid pulse.

There are two synchronous, active-high reset inputs. The power-on reset clears everything, including the latch. The manual reset clears only the read path and the synchroniser and leaves the latch untouched. Holding the block in a low-power state, with no strobes and no reset, keeps the latch as well.

Top module: `gpio_port_reg`

## Requirements
- R1: While `por_rst` is high at a clock edge, the latch (seen on `pin_out`) becomes 0x0000, `rd_data` becomes 0x0000 and `rd_valid` becomes 0.
- R2: `man_rst` leaves the latch unchanged. It only clears `rd_valid` and `rd_data`, and later reads return the latch as it was before the manual reset.
- R3: A 16-bit write (`acc_size`=1) at the base address loads all 16 bits of `acc_wdata`, and the new value is on `pin_out` after that clock edge.
- R4: An 8-bit write (`acc_size`=0) at the base address loads bits 15:8 from `acc_wdata[15:8]`. An 8-bit write at base+1 loads bits 7:0 from `acc_wdata[7:0]`. The other byte is kept.
- R5: For a pin whose `pin_dir_out` bit is 1, the read data bit is the latch bit, whatever the pin level.
- R6: For a pin whose `pin_dir_out` bit is 0, the read data bit is the pin level after two synchroniser flops. A read strobed at the first or second clock edge after a pin change still returns the old level. A read strobed at the third edge returns the new level.
- R7: A write to a bit whose pin is an input updates the latch but does not drive the pin: `pin_oe` for that bit stays 0.
- R8: When a pin's direction changes from input to output, `pin_oe` rises in the same cycle and `pin_out` already carries the latch bit, with no new write needed.
- R9: Every read strobe yields `rd_valid`=1 in the cycle after the strobe edge, for exactly one cycle. Without a read strobe, `rd_valid` is 0.
- R10: An 8-bit read at the base address returns the high byte in bits 15:8 with bits 7:0 zero. At base+1 it returns the low byte in bits 7:0 with bits 15:8 zero.
- R11: Accesses that miss do not write and read as 0x0000. A miss is any other word address, a 16-bit access at base+1, or any offset other than base and base+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears the latch |
| man_rst | input | 1 | Manual reset, synchronous, active high; latch kept |
| acc_req | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 1 | 0 = 8-bit, 1 = 16-bit access |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 16 | Write data, byte placed in its big-endian lane |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| pin_dir_out | input | 16 | Per-pin direction from the pin-function controller, 1 = output |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_out | output | 16 | Output drive value (latch content) |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The latch is loaded with walking-one and mixed patterns through word writes and through both byte lanes. Pin expectations come from a bench model of byte merging, which separates a correct lane from a swapped or lost byte. Reads then sweep direction masks from all-output to all-input, with pin levels chosen to differ from the latch. This shows whether each bit is chosen by its own direction bit. A pin change read back at one, two and three edges fixes the synchroniser depth. Writes made while the pins are inputs, a later direction flip, a manual reset and missed addresses check that the latch is kept or ignored exactly where the requirements say.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_kind_t;

    function automatic logic is_word(input acc_size_e sz);
        return sz == SZ_WORD;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_LANES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                 req,
    input  logic                 we,
    input  acc_size_e            size,
    input  logic [ADDR_W-1:0]    addr,
    output acc_kind_t            kind,
    output logic [NUM_LANES-1:0] lane_en
);
    localparam int OFF_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic             word_match;
    logic [OFF_W-1:0] offset;
    logic             hit;

    assign word_match = (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
    assign offset     = addr[OFF_W-1:0];

    always_comb begin
        lane_en = '0;
        if (word_match) begin
            if (is_word(size)) begin
                if (offset == '0) begin
                    lane_en = '1;
                end
            end else begin
                for (int i = 0; i < NUM_LANES; i++) begin
                    if (offset == OFF_W'(NUM_LANES - 1 - i)) begin
                        lane_en[i] = 1'b1;
                    end
                end
            end
        end
    end

    assign hit     = |lane_en;
    assign kind.wr = req & we & hit;
    assign kind.rd = req & ~we;

endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NUM_LANES = WIDTH / BYTE_W
) (
    input  logic                 clk,
    input  logic                 por_rst,
    input  logic                 wr,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     q
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (por_rst) begin
                q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (wr && lane_en[g]) begin
                q[g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NUM_LANES = WIDTH / BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_stb,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [WIDTH-1:0]     dir_out,
    input  logic [WIDTH-1:0]     stored,
    input  logic [WIDTH-1:0]     sampled,
    output logic [WIDTH-1:0]     rd_data,
    output logic                 rd_valid
);
    logic [WIDTH-1:0] picked;
    logic [WIDTH-1:0] mask;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign picked[i] = dir_out[i] ? stored[i] : sampled[i];
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
        assign mask[g*BYTE_W +: BYTE_W] = {BYTE_W{lane_en[g]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data <= picked & mask;
            end
        end
    end

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0A40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              man_rst,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic              acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WIDTH-1:0]  acc_wdata,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    input  logic [WIDTH-1:0]  pin_dir_out,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    localparam int NUM_LANES = WIDTH / BYTE_W;

    acc_kind_t            kind;
    logic [NUM_LANES-1:0] lane_en;
    logic [WIDTH-1:0]     latch_q;
    logic [WIDTH-1:0]     pin_sync;
    logic                 soft_rst;

    assign soft_rst = por_rst | man_rst;

    gpio_bus_decode #(
        .ADDR_W(ADDR_W),
        .NUM_LANES(NUM_LANES),
        .BASE_ADDR(BASE_ADDR)
    ) dec_i (
        .req(acc_req),
        .we(acc_we),
        .size(acc_size_e'(acc_size)),
        .addr(acc_addr),
        .kind(kind),
        .lane_en(lane_en)
    );

    gpio_data_latch #(
        .WIDTH(WIDTH),
        .NUM_LANES(NUM_LANES)
    ) latch_i (
        .clk(clk),
        .por_rst(por_rst),
        .wr(kind.wr),
        .lane_en(lane_en),
        .wdata(acc_wdata),
        .q(latch_q)
    );

    gpio_in_sync #(
        .WIDTH(WIDTH),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk(clk),
        .rst(soft_rst),
        .d(pin_in),
        .q(pin_sync)
    );

    gpio_read_mux #(
        .WIDTH(WIDTH),
        .NUM_LANES(NUM_LANES)
    ) rmux_i (
        .clk(clk),
        .rst(soft_rst),
        .rd_stb(kind.rd),
        .lane_en(lane_en),
        .dir_out(pin_dir_out),
        .stored(latch_q),
        .sampled(pin_sync),
        .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    assign pin_out = latch_q;
    assign pin_oe  = pin_dir_out;

endmodule

// File: rtl/gpio_port_reg_chk.sv
module gpio_port_reg_chk #(
    parameter int WIDTH = 16,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input logic              clk,
    input logic              por_rst,
    input logic              man_rst,
    input logic              acc_req,
    input logic              acc_we,
    input logic              acc_size,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [WIDTH-1:0]  acc_wdata,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_valid,
    input logic [WIDTH-1:0]  pin_dir_out,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe
);
    localparam int LANES = WIDTH / 8;
    localparam int OW = (LANES > 1) ? $clog2(LANES) : 1;

    logic any_rst;
    logic in_word;
    logic hit;
    logic rd_stb;
    logic wr_stb;

    assign any_rst = por_rst | man_rst;
    assign in_word = acc_addr[ADDR_W-1:OW] == BASE_ADDR[ADDR_W-1:OW];
    assign hit     = in_word && (acc_size ? (acc_addr[OW-1:0] == '0)
                                          : (int'(acc_addr[OW-1:0]) < LANES));
    assign rd_stb  = acc_req && !acc_we;
    assign wr_stb  = acc_req && acc_we;

    // R1
    p_por_clear_r1: assert property (@(posedge clk)
        por_rst |=> (pin_out == '0 && rd_data == '0 && !rd_valid));

    p_manrst_keep_r2: assert property (@(posedge clk) disable iff (por_rst)
        (man_rst && !wr_stb) |=> $stable(pin_out));

    p_word_write_r3: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && acc_size && acc_addr == BASE_ADDR) |=> pin_out == $past(acc_wdata));

    p_no_drive_change_r8: assert property (@(posedge clk) disable iff (por_rst)
        !wr_stb |=> $stable(pin_out));

    p_rd_pulse_r9: assert property (@(posedge clk) disable iff (any_rst)
        rd_stb |=> rd_valid);

    p_rd_idle_r9: assert property (@(posedge clk) disable iff (any_rst)
        !rd_stb |=> !rd_valid);

    p_miss_read_zero_r11: assert property (@(posedge clk) disable iff (any_rst)
        (rd_stb && !hit) |=> rd_data == '0);

    p_miss_no_write_r11: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && !hit) |=> $stable(pin_out));

    p_out_read_r5: assert property (@(posedge clk) disable iff (any_rst)
        (rd_stb && hit && acc_size && pin_dir_out == '1 && !wr_stb) |=> rd_data == $past(pin_out));

endmodule

bind gpio_port_reg gpio_port_reg_chk #(
    .WIDTH(WIDTH),
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR)
) chk_i (.*);

// File: tb/gpio_port_reg_tb_top.sv
module gpio_port_reg_tb_top;
    localparam logic [31:0] BASE = 32'h0000_0A40;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        man_rst = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_size = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [15:0] pin_dir_out = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model = '0;
    logic [15:0] got;

    always #10 clk = ~clk;

    gpio_port_reg dut_i (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
        .acc_req(acc_req), .acc_we(acc_we), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .pin_dir_out(pin_dir_out), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic sz, input logic [15:0] d);
        acc_req = 1'b1; acc_we = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] a, input logic sz, output logic [15:0] d);
        acc_req = 1'b1; acc_we = 1'b0; acc_addr = a; acc_size = sz;
        @(negedge clk);
        acc_req = 1'b0;
        d = rd_data;
        check("R9 rd_valid pulse", {15'd0, rd_valid}, 16'd1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin_out after por", pin_out, 16'h0000);
        check("R1 rd_data after por", rd_data, 16'h0000);
        check("R1 rd_valid after por", {15'd0, rd_valid}, 16'd0);
        por_rst = 1'b0;
        @(negedge clk);

        // R3 / R5: word writes, all outputs
        pin_dir_out = 16'hFFFF;
        pin_in = 16'h5A5A;
        for (int i = 0; i < 20; i++) begin
            logic [15:0] v;
            v = (i < 16) ? (16'h1 << i) : 16'(16'hA5C3 * (i + 1));
            do_write(BASE, 1'b1, v);
            model = v;
            check("R3 word write pin_out", pin_out, model);
            do_read(BASE, 1'b1, got);
            check("R5 output read returns latch", got, model);
            @(negedge clk);
            check("R9 rd_valid single cycle", {15'd0, rd_valid}, 16'd0);
        end

        // R4 byte writes, R10 byte reads
        for (int i = 0; i < 8; i++) begin
            logic [7:0] hi;
            logic [7:0] lo;
            hi = 8'(8'h37 * (i + 1));
            lo = 8'(8'hC1 ^ (i * 29));
            do_write(BASE, 1'b0, {hi, ~hi});
            model[15:8] = hi;
            check("R4 high byte write", pin_out, model);
            do_write(BASE + 1, 1'b0, {~lo, lo});
            model[7:0] = lo;
            check("R4 low byte write", pin_out, model);
            do_read(BASE, 1'b0, got);
            check("R10 high byte read", got, {model[15:8], 8'h00});
            do_read(BASE + 1, 1'b0, got);
            check("R10 low byte read", got, {8'h00, model[7:0]});
        end

        // R5 / R6 direction sweep
        for (int k = 0; k <= 16; k++) begin
            logic [15:0] dirm;
            logic [15:0] pins;
            dirm = (k == 16) ? 16'h0000 : (16'hFFFF >> k) ^ (16'h1 << k);
            pins = ~model ^ 16'(k * 16'h1111);
            pin_dir_out = dirm;
            pin_in = pins;
            repeat (2) @(negedge clk);
            do_read(BASE, 1'b1, got);
            check("R6 R5 mixed direction read", got, (model & dirm) | (pins & ~dirm));
        end

        // R6 synchroniser depth
        pin_dir_out = 16'h0000;
        pin_in = 16'h1234;
        repeat (3) @(negedge clk);
        pin_in = 16'hEDCB;
        do_read(BASE, 1'b1, got);
        check("R6 first edge old level", got, 16'h1234);
        do_read(BASE, 1'b1, got);
        check("R6 second edge old level", got, 16'h1234);
        do_read(BASE, 1'b1, got);
        check("R6 third edge new level", got, 16'hEDCB);

        // R7 write while input, R8 flip to output
        do_write(BASE, 1'b1, 16'h3C96);
        model = 16'h3C96;
        check("R7 input pins not driven", pin_oe, 16'h0000);
        do_read(BASE, 1'b1, got);
        check("R7 input read returns pin", got, 16'hEDCB);
        pin_dir_out = 16'hFFFF;
        #1;
        check("R8 oe rises at once", pin_oe, 16'hFFFF);
        check("R8 drives stored value", pin_out, 16'h3C96);
        @(negedge clk);
        do_read(BASE, 1'b1, got);
        check("R7 stored while input", got, 16'h3C96);

        // R2 manual reset keeps latch
        acc_req = 1'b1; acc_we = 1'b0; acc_addr = BASE; acc_size = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        man_rst = 1'b1;
        @(negedge clk);
        check("R2 rd_valid cleared", {15'd0, rd_valid}, 16'd0);
        check("R2 rd_data cleared", rd_data, 16'h0000);
        @(negedge clk);
        man_rst = 1'b0;
        check("R2 latch kept", pin_out, model);
        do_read(BASE, 1'b1, got);
        check("R2 read after manual reset", got, model);

        // R11 misses
        do_write(BASE + 2, 1'b1, 16'hFFFF);
        check("R11 other word no write", pin_out, model);
        do_write(BASE + 1, 1'b1, 16'h0000);
        check("R11 misaligned word no write", pin_out, model);
        do_write(BASE + 4, 1'b0, 16'h0000);
        check("R11 other byte no write", pin_out, model);
        do_read(BASE + 2, 1'b1, got);
        check("R11 miss read zero", got, 16'h0000);
        do_read(BASE + 1, 1'b1, got);
        check("R11 misaligned read zero", got, 16'h0000);
        do_read(BASE - 1, 1'b0, got);
        check("R11 byte miss read zero", got, 16'h0000);

        // R1 power-on reset clears latch
        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
        check("R1 latch cleared", pin_out, 16'h0000);
        @(negedge clk);
        summary();
    end

endmodule